// File: doc/BRIEF.md
# Video Memory Bank Slot Mapper

This block places up to nine external memory banks into a window of 32 equal address slots and steers each access to the banks that currently sit behind the addressed slot. Each bank has its own control byte. The byte says whether the bank is placed at all, in which mode, and at which offset. The block keeps one bank bitmask for each slot and rebuilds the affected masks whenever a control byte changes. Banks that are placed in the plain processor view are reported on a separate per-bank vector and take no slot.

Several banks can share a slot. A write through such a slot reaches every bank behind it. A read returns the bitwise OR of all their data. A slot with no bank reads as zero and drops writes. The bank memories themselves are outside the block. It drives a per-bank enable, a per-bank write strobe, a bank-relative word address and shared write data, and it takes back one read word per bank. The banks are expected to answer one cycle after the enable.

Top module: `vram_bank_mapper`

## Requirements
- R1: A control byte is decoded as follows. Bit 7 enables the bank. The mode is bits [1:0] for banks 0, 1, 7 and 8, and bits [2:0] for banks 2 to 6. The offset is bits [4:3] for banks 0 and 1, and bits [5:3] for banks 2 to 6. A byte with bit 7 clear places the bank nowhere.
- R2: Banks 0 to 3 in mode 1 fill the eight slots from offset×8 to offset×8+7. An offset of 4 or more places them in no slot.
- R3: Bank 4 in mode 1 fills slots 0 to 3, whatever its offset.
- R4: Banks 5 and 6 in mode 1 sit at slot s = ofs[0] + 4·ofs[1] and again at slot s+2. Both slots reach the same bank words.
- R5: An enabled bank in mode 0 sets its bit in `cpu_view` and occupies no slot. Any other setting clears that bit.
- R6: Writing a control byte equal to the stored one changes nothing. A different byte removes the bank's old placement and applies the new one in the same update.
- R7: A read presented in cycle t returns, on `acc_rdata` in cycle t+1, the OR of the read words of all banks mapped to the slot.
- R8: A write asserts the enable and the write strobe of every bank mapped to the slot and of no other bank.
- R9: An access to a slot with an empty mask enables no bank, and a read from it returns zero.
- R10: Bank 2 (status bit 0) and bank 3 (status bit 1) set their `cd_status` bit when a changed control byte puts them into enabled mode 2. Any control write to that bank first clears the bit, including a write of an identical byte.
- R11: Reset clears all control bytes, all slot masks, `cpu_view` and `cd_status`.
- R12: When a control write and an access fall in the same cycle, the access uses the mapping that was in force before the write.
- R13: The bank-relative address is {local slot, word}. The local slot is slot[2:0] for banks 0 to 3, slot[1:0] for bank 4, and zero for banks 5 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_bank | input | 4 | Bank index of the control write (0 to 8) |
| cfg_byte | input | 8 | New control byte |
| acc_req | input | 1 | Access request |
| acc_we | input | 1 | Access is a write |
| acc_addr | input | 5+WORD_AW | Slot index in the top 5 bits, word within the slot below |
| acc_wdata | input | DATA_W | Write data |
| acc_rdata | output | DATA_W | Read data, one cycle after the request |
| bank_en | output | 9 | Per-bank enable |
| bank_we | output | 9 | Per-bank write strobe |
| bank_addr | output | 9*(3+WORD_AW) | Bank-relative word address, bank b at slice b |
| bank_wdata | output | DATA_W | Write data to all banks |
| bank_rdata | input | 9*DATA_W | Read words from the banks, bank b at slice b |
| cpu_view | output | 9 | Banks placed in the processor view |
| cd_status | output | 2 | Mode-2 status of banks 2 and 3 |

## Verification
A control rewrite and a bank access can land in the same clock cycle. The question is whether the access sees the old placement or the new one. The bench provokes this by unmapping a bank in the very cycle it reads a slot that only that bank fills. It then judges the enable vector seen during that cycle and the data returned one cycle later against the old placement. A probe in the next cycle must show the slot empty.

// File: rtl/vbm_pkg.sv
package vbm_pkg;

  localparam int NUM_BANKS = 9;
  localparam int NUM_SLOTS = 32;
  localparam int SLOT_W    = 5;
  localparam int LSLOT_W   = 3;

  localparam int unsigned BK_B = 1;
  localparam int unsigned BK_C = 2;
  localparam int unsigned BK_D = 3;
  localparam int unsigned BK_E = 4;
  localparam int unsigned BK_F = 5;
  localparam int unsigned BK_G = 6;
  localparam int unsigned BK_H = 7;

  localparam logic [2:0] MODE_CPU = 3'd0;
  localparam logic [2:0] MODE_BG  = 3'd1;
  localparam logic [2:0] MODE_ALT = 3'd2;

  typedef logic [NUM_BANKS-1:0] bank_vec_t;

  // mode field: two bits on the large pair and the two tail banks, three elsewhere
  function automatic logic [2:0] vbm_mode(input int unsigned b, input logic [7:0] c);
    if (b <= BK_B || b >= BK_H) return {1'b0, c[1:0]};
    return c[2:0];
  endfunction

  function automatic logic [2:0] vbm_ofs(input int unsigned b, input logic [7:0] c);
    if (b <= BK_B) return {1'b0, c[4:3]};
    return c[5:3];
  endfunction

  function automatic logic vbm_cpu_bit(input int unsigned b, input logic [7:0] c);
    return c[7] && (vbm_mode(b, c) == MODE_CPU);
  endfunction

  // slots a bank fills in the background window
  function automatic logic [NUM_SLOTS-1:0] vbm_bg_slots(input int unsigned b, input logic [7:0] c);
    logic [NUM_SLOTS-1:0] r;
    logic [2:0]           o;
    int unsigned          s;
    r = '0;
    o = vbm_ofs(b, c);
    if (c[7] && vbm_mode(b, c) == MODE_BG) begin
      if (b <= BK_D) begin
        if (o < 3'd4) r = {{(NUM_SLOTS-8){1'b0}}, 8'hFF} << {o[1:0], 3'b000};
      end else if (b == BK_E) begin
        r[3:0] = 4'hF;
      end else if (b == BK_F || b == BK_G) begin
        s = int'(o[0]) + 4 * int'(o[1]);
        r[s]     = 1'b1;
        r[s + 2] = 1'b1;
      end
    end
    return r;
  endfunction

  // slot index seen from inside the bank
  function automatic logic [LSLOT_W-1:0] vbm_local_slot(input int unsigned b, input logic [SLOT_W-1:0] slot);
    if (b <= BK_D) return slot[2:0];
    if (b == BK_E) return {1'b0, slot[1:0]};
    return '0;
  endfunction

endpackage

// File: rtl/vbm_ctrl_file.sv
module vbm_ctrl_file
  import vbm_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_we,
  input  logic [3:0]                     cfg_bank,
  input  logic [7:0]                     cfg_byte,
  output logic [NUM_BANKS-1:0][7:0]      ctrl_q,
  output bank_vec_t                      cpu_view,
  output logic [1:0]                     cd_status,
  output logic                           upd_valid,
  output logic [3:0]                     upd_bank,
  output logic [7:0]                     upd_byte
);

  logic       bank_ok;
  logic [7:0] cur_byte;
  logic       changed;
  logic       enters_alt;

  assign bank_ok    = cfg_bank < 4'(NUM_BANKS);
  assign cur_byte   = bank_ok ? ctrl_q[cfg_bank] : 8'h00;
  assign changed    = cfg_we && bank_ok && (cfg_byte != cur_byte);
  assign enters_alt = cfg_byte[7] && (vbm_mode(int'(cfg_bank), cfg_byte) == MODE_ALT);

  assign upd_valid = changed;
  assign upd_bank  = cfg_bank;
  assign upd_byte  = cfg_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      cpu_view  <= '0;
      cd_status <= '0;
    end else if (cfg_we && bank_ok) begin
      if (changed) begin
        ctrl_q[cfg_bank]   <= cfg_byte;
        cpu_view[cfg_bank] <= vbm_cpu_bit(int'(cfg_bank), cfg_byte);
      end
      if (cfg_bank == 4'(BK_C)) cd_status[0] <= changed && enters_alt;
      if (cfg_bank == 4'(BK_D)) cd_status[1] <= changed && enters_alt;
    end
  end

  assert_same_byte_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && bank_ok && cfg_byte == cur_byte) |=> $stable(ctrl_q));

  assert_status_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_bank == 4'(BK_C) && cfg_byte == cur_byte) |=> !cd_status[0]);

  assert_status_implies_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cd_status[1] |-> (ctrl_q[BK_D][7] && ctrl_q[BK_D][2:0] == MODE_ALT));

endmodule

// File: rtl/vbm_slot_map.sv
module vbm_slot_map
  import vbm_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              upd_valid,
  input  logic [3:0]                        upd_bank,
  input  logic [7:0]                        upd_byte,
  input  logic [NUM_BANKS-1:0][7:0]         ctrl_q,
  output logic [NUM_SLOTS-1:0][NUM_BANKS-1:0] slot_mask
);

  logic [NUM_SLOTS-1:0] new_place;

  assign new_place = vbm_bg_slots(int'(upd_bank), upd_byte);

  // one mask per slot; a rewrite replaces the bank's column as a whole,
  // which removes the old placement and sets the new one in one edge
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_mask[s] <= '0;
      end else if (upd_valid) begin
        for (int b = 0; b < NUM_BANKS; b++) begin
          if (upd_bank == 4'(b)) slot_mask[s][b] <= new_place[s];
        end
      end
    end
  end

  // placement implied by the stored control bytes
  logic [NUM_SLOTS-1:0][NUM_BANKS-1:0] implied;
  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        implied[s][b] = vbm_bg_slots(b, ctrl_q[b])[s];
      end
    end
  end

  assert_map_tracks_ctrl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    slot_mask == implied);

endmodule

// File: rtl/vbm_router.sv
module vbm_router
  import vbm_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int WORD_AW = 4,
  localparam int ADDR_W  = SLOT_W + WORD_AW,
  localparam int BANK_AW = LSLOT_W + WORD_AW
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NUM_SLOTS-1:0][NUM_BANKS-1:0]  slot_mask,
  input  logic                                 acc_req,
  input  logic                                 acc_we,
  input  logic [ADDR_W-1:0]                    acc_addr,
  input  logic [DATA_W-1:0]                    acc_wdata,
  output logic [DATA_W-1:0]                    acc_rdata,
  output bank_vec_t                            bank_en,
  output bank_vec_t                            bank_we,
  output logic [NUM_BANKS-1:0][BANK_AW-1:0]    bank_addr,
  output logic [DATA_W-1:0]                    bank_wdata,
  input  logic [NUM_BANKS-1:0][DATA_W-1:0]     bank_rdata
);

  logic [SLOT_W-1:0]  slot;
  logic [WORD_AW-1:0] word;
  bank_vec_t          hit;
  bank_vec_t          hit_q;

  assign slot = acc_addr[ADDR_W-1 -: SLOT_W];
  assign word = acc_addr[WORD_AW-1:0];
  assign hit  = acc_req ? slot_mask[slot] : '0;

  assign bank_en    = hit;
  assign bank_we    = acc_we ? hit : '0;
  assign bank_wdata = acc_wdata;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_addr
    assign bank_addr[b] = {vbm_local_slot(b, slot), word};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= '0;
    else        hit_q <= (acc_req && !acc_we) ? hit : '0;
  end

  always_comb begin
    acc_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (hit_q[b]) acc_rdata = acc_rdata | bank_rdata[b];
    end
  end

  assert_empty_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && !acc_we && bank_en == '0) |=> acc_rdata == '0);

  assert_write_fanout_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && acc_we) |-> (bank_we == bank_en));

endmodule

// File: rtl/vram_bank_mapper.sv
module vram_bank_mapper
  import vbm_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int WORD_AW = 4,
  localparam int ADDR_W  = SLOT_W + WORD_AW,
  localparam int BANK_AW = LSLOT_W + WORD_AW
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [3:0]                    cfg_bank,
  input  logic [7:0]                    cfg_byte,
  input  logic                          acc_req,
  input  logic                          acc_we,
  input  logic [ADDR_W-1:0]             acc_addr,
  input  logic [DATA_W-1:0]             acc_wdata,
  output logic [DATA_W-1:0]             acc_rdata,
  output logic [NUM_BANKS-1:0]          bank_en,
  output logic [NUM_BANKS-1:0]          bank_we,
  output logic [NUM_BANKS*BANK_AW-1:0]  bank_addr,
  output logic [DATA_W-1:0]             bank_wdata,
  input  logic [NUM_BANKS*DATA_W-1:0]   bank_rdata,
  output logic [NUM_BANKS-1:0]          cpu_view,
  output logic [1:0]                    cd_status
);

  logic [NUM_BANKS-1:0][7:0]           ctrl_q;
  logic                                upd_valid;
  logic [3:0]                          upd_bank;
  logic [7:0]                          upd_byte;
  logic [NUM_SLOTS-1:0][NUM_BANKS-1:0] slot_mask;
  logic [NUM_BANKS-1:0][BANK_AW-1:0]   addr_vec;
  logic [NUM_BANKS-1:0][DATA_W-1:0]    rdata_vec;

  assign bank_addr = addr_vec;
  assign rdata_vec = bank_rdata;

  vbm_ctrl_file u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_bank  (cfg_bank),
    .cfg_byte  (cfg_byte),
    .ctrl_q    (ctrl_q),
    .cpu_view  (cpu_view),
    .cd_status (cd_status),
    .upd_valid (upd_valid),
    .upd_bank  (upd_bank),
    .upd_byte  (upd_byte)
  );

  vbm_slot_map u_map (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_valid (upd_valid),
    .upd_bank  (upd_bank),
    .upd_byte  (upd_byte),
    .ctrl_q    (ctrl_q),
    .slot_mask (slot_mask)
  );

  vbm_router #(.DATA_W(DATA_W), .WORD_AW(WORD_AW)) u_route (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_mask  (slot_mask),
    .acc_req    (acc_req),
    .acc_we     (acc_we),
    .acc_addr   (acc_addr),
    .acc_wdata  (acc_wdata),
    .acc_rdata  (acc_rdata),
    .bank_en    (bank_en),
    .bank_we    (bank_we),
    .bank_addr  (addr_vec),
    .bank_wdata (bank_wdata),
    .bank_rdata (rdata_vec)
  );

  // which banks own at least one slot
  bank_vec_t slot_owner;
  always_comb begin
    slot_owner = '0;
    for (int s = 0; s < NUM_SLOTS; s++) slot_owner = slot_owner | slot_mask[s];
  end

  assert_cpu_view_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_view & slot_owner) == '0);

  assert_reset_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cpu_view == '0 && cd_status == 2'b00 && slot_owner == '0));

endmodule

// File: tb/vram_bank_mapper_tb.sv
module vram_bank_mapper_tb;

  localparam int NB  = 9;
  localparam int DW  = 32;
  localparam int WA  = 4;
  localparam int BAW = 3 + WA;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfg_we = 1'b0;
  logic [3:0]      cfg_bank = '0;
  logic [7:0]      cfg_byte = '0;
  logic            acc_req = 1'b0;
  logic            acc_we = 1'b0;
  logic [5+WA-1:0] acc_addr = '0;
  logic [DW-1:0]   acc_wdata = '0;
  logic [DW-1:0]   acc_rdata;
  logic [NB-1:0]   bank_en, bank_we, cpu_view;
  logic [NB*BAW-1:0] bank_addr;
  logic [DW-1:0]   bank_wdata;
  logic [NB*DW-1:0] bank_rdata;
  logic [1:0]      cd_status;

  always #10 clk = ~clk;

  vram_bank_mapper #(.DATA_W(DW), .WORD_AW(WA)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bank(cfg_bank), .cfg_byte(cfg_byte),
    .acc_req(acc_req), .acc_we(acc_we), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .bank_en(bank_en), .bank_we(bank_we), .bank_addr(bank_addr),
    .bank_wdata(bank_wdata), .bank_rdata(bank_rdata), .cpu_view(cpu_view), .cd_status(cd_status)
  );

  // bank models: synchronous read, one cycle latency
  logic [DW-1:0] mem [NB][1<<BAW];
  logic [DW-1:0] brd [NB];
  always @(posedge clk) begin
    for (int b = 0; b < NB; b++) begin
      if (bank_en[b]) begin
        if (bank_we[b]) mem[b][bank_addr[b*BAW +: BAW]] <= bank_wdata;
        else            brd[b] <= mem[b][bank_addr[b*BAW +: BAW]];
      end
    end
  end
  always_comb begin
    for (int b = 0; b < NB; b++) bank_rdata[b*DW +: DW] = brd[b];
  end

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic cfg_write(input logic [3:0] b, input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_bank = b; cfg_byte = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(input logic [4:0] slot, input logic [WA-1:0] word, input logic we,
                        input logic [DW-1:0] wd, output logic [NB-1:0] en_seen,
                        output logic [DW-1:0] rd);
    @(negedge clk);
    acc_req = 1'b1; acc_we = we; acc_addr = {slot, word}; acc_wdata = wd;
    #1 en_seen = bank_en;
    @(negedge clk);
    acc_req = 1'b0; acc_we = 1'b0;
    rd = acc_rdata;
  endtask

  typedef struct packed {
    logic [3:0] bank;
    logic [7:0] byte_v;
    logic [4:0] slot;
    logic [8:0] exp_en;
    logic [8:0] exp_view;
  } vec_t;

  // cumulative walk: each row rewrites one control byte and probes one slot
  localparam vec_t VEC [12] = '{
    '{4'd0, 8'h81, 5'd3,  9'h001, 9'h000},  // R2 bank0 slots 0..7
    '{4'd1, 8'h89, 5'd15, 9'h002, 9'h000},  // R2 bank1 slots 8..15
    '{4'd4, 8'h99, 5'd2,  9'h011, 9'h000},  // R3 offset ignored
    '{4'd5, 8'h91, 5'd6,  9'h021, 9'h000},  // R4 s=4, mirror 6
    '{4'd6, 8'h89, 5'd3,  9'h051, 9'h000},  // R4 s=1, mirror 3
    '{4'd2, 8'h91, 5'd16, 9'h004, 9'h000},  // R2 bank2 slots 16..23
    '{4'd3, 8'hA1, 5'd24, 9'h000, 9'h000},  // R2 offset 4 places nothing
    '{4'd0, 8'h91, 5'd3,  9'h050, 9'h000},  // R6 old placement removed
    '{4'd7, 8'h80, 5'd20, 9'h005, 9'h080},  // R5 bank7 to cpu view
    '{4'd1, 8'h09, 5'd8,  9'h000, 9'h080},  // R1 disabled byte unmaps
    '{4'd0, 8'h80, 5'd16, 9'h004, 9'h081},  // R5 mode 0 leaves slots
    '{4'd1, 8'h8D, 5'd9,  9'h002, 9'h081}   // R1 bit 2 ignored on bank1
  };

  initial begin
    logic [NB-1:0] en;
    logic [DW-1:0] rd;
    for (int b = 0; b < NB; b++) begin
      brd[b] = '0;
      for (int a = 0; a < (1 << BAW); a++) mem[b][a] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 cpu_view after reset", 32'(cpu_view), 32'h0);
    check("R11 cd_status after reset", 32'(cd_status), 32'h0);
    access(5'd0, 4'd0, 1'b0, '0, en, rd);
    check("R11 slot0 empty after reset", 32'(en), 32'h0);
    check("R9 empty slot reads zero", rd, 32'h0);

    for (int i = 0; i < 12; i++) begin
      cfg_write(VEC[i].bank, VEC[i].byte_v);
      access(VEC[i].slot, 4'd0, 1'b0, '0, en, rd);
      check($sformatf("R1/R2 row %0d bank_en", i), 32'(en), 32'(VEC[i].exp_en));
      check($sformatf("R5 row %0d cpu_view", i), 32'(cpu_view), 32'(VEC[i].exp_view));
    end

    // R4 mirror reaches the same words; R13 local address zero for bank5
    access(5'd4, 4'd2, 1'b1, 32'h0000_00F0, en, rd);
    check("R4 write slot4 enables bank5", 32'(en), 32'h020);
    access(5'd6, 4'd2, 1'b0, '0, en, rd);
    check("R4 mirror slot6 read", rd, 32'h0000_00F0);
    check("R13 bank5 local addr", 32'(mem[5][2]), 32'h0000_00F0);

    // R7 overlap OR
    cfg_write(4'd0, 8'h91);
    @(negedge clk);
    mem[0][7] = 32'h00FF_0000;
    mem[2][7] = 32'h0000_00AA;
    access(5'd16, 4'd7, 1'b0, '0, en, rd);
    check("R7 overlap enables", 32'(en), 32'h005);
    check("R7 OR of two banks", rd, 32'h00FF_00AA);

    // R8 write fan-out, R13 local slot 1
    access(5'd17, 4'd1, 1'b1, 32'hCAFE_0001, en, rd);
    check("R8 write enables both", 32'(en), 32'h005);
    check("R8 bank0 written", mem[0][17], 32'hCAFE_0001);
    check("R8 bank2 written", mem[2][17], 32'hCAFE_0001);

    // R9 empty slot
    access(5'd30, 4'd3, 1'b1, 32'h1111_2222, en, rd);
    check("R9 write to empty slot", 32'(en), 32'h0);
    access(5'd30, 4'd3, 1'b0, '0, en, rd);
    check("R9 read empty slot", rd, 32'h0);

    // R10 status bits
    cfg_write(4'd2, 8'h82);
    check("R10 bank2 mode2 sets bit0", 32'(cd_status), 32'h1);
    access(5'd16, 4'd0, 1'b0, '0, en, rd);
    check("R6 bank2 left slot16", 32'(en), 32'h001);
    cfg_write(4'd2, 8'h82);
    check("R10 identical write clears bit0", 32'(cd_status), 32'h0);
    cfg_write(4'd3, 8'h8A);
    check("R10 bank3 mode2 sets bit1", 32'(cd_status), 32'h2);
    cfg_write(4'd3, 8'h81);
    check("R10 bank3 leaves mode2", 32'(cd_status), 32'h0);
    access(5'd0, 4'd0, 1'b0, '0, en, rd);
    check("R2 bank3 joins slot0", 32'(en), 32'h018);

    // R12 same-cycle control write and read
    @(negedge clk);
    cfg_we = 1'b1; cfg_bank = 4'd0; cfg_byte = 8'h00;
    acc_req = 1'b1; acc_we = 1'b0; acc_addr = {5'd16, 4'd7};
    #1 check("R12 old mapping enables", 32'(bank_en), 32'h001);
    @(negedge clk);
    cfg_we = 1'b0; acc_req = 1'b0;
    check("R12 old mapping data", acc_rdata, 32'h00FF_0000);
    access(5'd16, 4'd7, 1'b0, '0, en, rd);
    check("R12 new mapping after", 32'(en), 32'h000);

    // R11 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 cpu_view cleared", 32'(cpu_view), 32'h0);
    access(5'd0, 4'd0, 1'b0, '0, en, rd);
    check("R11 slot0 cleared", 32'(en), 32'h0);
    access(5'd8, 4'd0, 1'b0, '0, en, rd);
    check("R11 slot8 cleared", 32'(en), 32'h0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule